// File: doc/BRIEF.md
# Three-Wire Control Port Decoder

This block receives configuration writes from a host microcontroller over a three-wire serial bus: a phase line, a bit clock and a data line. Traffic runs one way only, from the host into the block. All three lines are asynchronous to the system clock. The block synchronises them with two flops each and samples the data line on every rising edge of the bus clock. A low phase line marks an address byte and a high phase line marks a data byte. Bytes are eight bits long and arrive least significant bit first.

An address byte holds a six-bit device address in its upper bits and a two-bit transfer type in its lower bits. When the address matches, the block becomes selected and stores the transfer type, which picks one of two register banks: audio settings or system settings. Each data byte that follows, for as long as the block stays selected, names a register with its top two bits and carries a six-bit value in the rest. The stored fields drive the rest of the chip: clock select, input format, volume code, de-emphasis code and mute.

Top module: `ctl3w_decoder`

## Requirements
- R1: While reset is high, every output field is cleared to zero and the block is deselected. A data byte sent after reset without a preceding address byte changes nothing.
- R2: A byte is assembled from eight rising edges of the bus clock, least significant bit first. A low phase line marks an address byte and a high phase line marks a data byte.
- R3: An address byte whose bits 7:2 equal 000101 selects the block. Any other address deselects it, and data bytes are then ignored until a matching address is received.
- R4: Address bits 1:0 pick the bank. 00 selects the audio bank and 10 selects the system bank. With 01 or 11, data bytes write nothing.
- R5: The selection and the bank stay in force across any number of consecutive data bytes.
- R6: A byte with fewer than eight bits never changes a register. Any change on the phase line restarts bit counting at zero.
- R7: In the audio bank, a data byte with bits 7:6 = 00 stores bits 5:0 as the volume code.
- R8: In the audio bank, a data byte with bits 7:6 = 10 stores bits 4:3 as the de-emphasis code and bit 2 as mute.
- R9: In the audio bank, bits 7:6 = 11 with bits 5:0 = 000001 returns every field to zero. Any other value under 11, and any byte with bits 7:6 = 01, has no effect.
- R10: In the system bank, bits 7:6 = 00 stores bits 5:4 as clock select and bits 3:1 as input format. Any other selector has no effect.
- R11: A register update is visible at the outputs within four system clock cycles after the eighth rising edge of the bus clock. The system clock runs at least four times faster than the bus clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cb_mode | input | 1 | Bus phase line: low for address, high for data |
| cb_clk | input | 1 | Bus bit clock, idles high |
| cb_dat | input | 1 | Bus serial data |
| clk_sel | output | 2 | Stored clock select |
| in_fmt | output | 3 | Stored input format |
| vol | output | 6 | Stored volume code |
| deemph | output | 2 | Stored de-emphasis code |
| mute | output | 1 | Stored mute flag |

## Verification
A wrong bit count or a bad phase-change restart shows up as a shifted or misframed value in a field. It appears within four cycles of the byte that should have been committed, or as an update where a partial byte should have left the field alone. A wrong select flag or bank is invisible until the next data byte. That byte then either writes a field it should leave alone or fails to write the one it targets, so each check follows a full address-and-data pair. A wrong default or a broken restore command shows up at the outputs immediately after reset or right after the restore byte.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 6;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam logic [ADDR_W-1:0] DEV_ADDR = 6'b000101;
    localparam logic [5:0] RESTORE_CODE = 6'b000001;

    typedef enum logic [1:0] {
        XFER_AUDIO  = 2'b00,
        XFER_NONE_A = 2'b01,
        XFER_SYSTEM = 2'b10,
        XFER_NONE_B = 2'b11
    } xfer_e;

    typedef enum logic [1:0] {
        RSEL_PRIMARY = 2'b00,
        RSEL_SPARE   = 2'b01,
        RSEL_SECOND  = 2'b10,
        RSEL_COMMAND = 2'b11
    } rsel_e;

    typedef struct packed {
        logic [1:0] clk_sel;
        logic [2:0] in_fmt;
        logic [5:0] vol;
        logic [1:0] deemph;
        logic       mute;
    } cfg_t;

    typedef struct packed {
        logic              is_addr;
        logic [BYTE_W-1:0] bits;
    } rx_byte_t;

    function automatic cfg_t cfg_defaults();
        return '0;
    endfunction

    function automatic logic addr_hit(logic [BYTE_W-1:0] b);
        return b[BYTE_W-1:BYTE_W-ADDR_W] == DEV_ADDR;
    endfunction

endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mode_i,
    input  logic sclk_i,
    input  logic sdat_i,
    output logic mode_o,
    output logic dat_o,
    output logic rise_o,
    output logic mode_chg_o
);
    // Bit order within each stage: {mode, clk, dat}; the bus clock idles high.
    localparam logic [2:0] IDLE = 3'b010;

    logic [2:0] pipe [STAGES];
    logic       clk_prev;
    logic       mode_prev;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= IDLE;
                else     pipe[s] <= {mode_i, sclk_i, sdat_i};
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= IDLE;
                else     pipe[s] <= pipe[s-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_prev  <= 1'b1;
            mode_prev <= 1'b0;
        end else begin
            clk_prev  <= pipe[STAGES-1][1];
            mode_prev <= pipe[STAGES-1][2];
        end
    end

    assign mode_o     = pipe[STAGES-1][2];
    assign dat_o      = pipe[STAGES-1][0];
    assign rise_o     = pipe[STAGES-1][1] & ~clk_prev;
    assign mode_chg_o = pipe[STAGES-1][2] ^ mode_prev;
endmodule

// File: rtl/ctl3w_shifter.sv
module ctl3w_shifter
    import ctl3w_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     mode,
    input  logic     dat,
    input  logic     rise,
    input  logic     mode_chg,
    output logic     rx_vld,
    output rx_byte_t rx
);
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] shnext;

    assign shnext = {dat, shreg[BYTE_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            shreg  <= '0;
            rx_vld <= 1'b0;
            rx     <= '0;
        end else begin
            rx_vld <= 1'b0;
            if (mode_chg) begin
                cnt <= '0;
            end else if (rise) begin
                shreg <= shnext;
                if (cnt == CNT_W'(BYTE_W - 1)) begin
                    cnt        <= '0;
                    rx_vld     <= 1'b1;
                    rx.bits    <= shnext;
                    rx.is_addr <= ~mode;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ctl3w_regfile.sv
module ctl3w_regfile
    import ctl3w_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     rx_vld,
    input  rx_byte_t rx,
    output cfg_t     cfg,
    output logic     sel_q,
    output xfer_e    xfer_q
);
    rsel_e      rsel;
    logic [5:0] val;

    assign rsel = rsel_e'(rx.bits[7:6]);
    assign val  = rx.bits[5:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= cfg_defaults();
            sel_q  <= 1'b0;
            xfer_q <= XFER_AUDIO;
        end else if (rx_vld) begin
            if (rx.is_addr) begin
                sel_q  <= addr_hit(rx.bits);
                xfer_q <= xfer_e'(rx.bits[1:0]);
            end else if (sel_q) begin
                unique case (xfer_q)
                    XFER_AUDIO: begin
                        if (rsel == RSEL_PRIMARY) begin
                            cfg.vol <= val;
                        end else if (rsel == RSEL_SECOND) begin
                            cfg.deemph <= val[4:3];
                            cfg.mute   <= val[2];
                        end else if (rsel == RSEL_COMMAND && val == RESTORE_CODE) begin
                            cfg <= cfg_defaults();
                        end
                    end
                    XFER_SYSTEM: begin
                        if (rsel == RSEL_PRIMARY) begin
                            cfg.clk_sel <= val[5:4];
                            cfg.in_fmt  <= val[3:1];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/ctl3w_decoder.sv
module ctl3w_decoder
    import ctl3w_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cb_mode,
    input  logic       cb_clk,
    input  logic       cb_dat,
    output logic [1:0] clk_sel,
    output logic [2:0] in_fmt,
    output logic [5:0] vol,
    output logic [1:0] deemph,
    output logic       mute
);
    logic     s_mode;
    logic     s_dat;
    logic     s_rise;
    logic     s_chg;
    logic     rx_vld;
    rx_byte_t rx;
    cfg_t     cfg_q;
    logic     sel_q;
    xfer_e    xfer_q;

    ctl3w_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (cb_mode),
        .sclk_i     (cb_clk),
        .sdat_i     (cb_dat),
        .mode_o     (s_mode),
        .dat_o      (s_dat),
        .rise_o     (s_rise),
        .mode_chg_o (s_chg)
    );

    ctl3w_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .mode     (s_mode),
        .dat      (s_dat),
        .rise     (s_rise),
        .mode_chg (s_chg),
        .rx_vld   (rx_vld),
        .rx       (rx)
    );

    ctl3w_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .rx_vld (rx_vld),
        .rx     (rx),
        .cfg    (cfg_q),
        .sel_q  (sel_q),
        .xfer_q (xfer_q)
    );

    assign clk_sel = cfg_q.clk_sel;
    assign in_fmt  = cfg_q.in_fmt;
    assign vol     = cfg_q.vol;
    assign deemph  = cfg_q.deemph;
    assign mute    = cfg_q.mute;
endmodule

// File: rtl/ctl3w_checker.sv
module ctl3w_checker (
    input logic        clk,
    input logic        rst,
    input logic        rise,
    input logic        rx_vld,
    input logic        rx_addr,
    input logic [7:0]  rx_bits,
    input logic        sel_q,
    input logic [1:0]  xfer,
    input logic [13:0] cfg_flat,
    input logic [5:0]  vol,
    input logic [1:0]  deemph,
    input logic        mute
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (cfg_flat == '0 && !sel_q)); // R1

    AST_BYTE_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
        rx_vld |-> $past(rise)); // R2

    AST_DESEL_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (rx_vld && !rx_addr && !sel_q) |=> $stable(cfg_flat)); // R3

    AST_UNUSED_XFER: assert property (@(posedge clk) disable iff (rst)
        (rx_vld && !rx_addr && sel_q && xfer[0]) |=> $stable(cfg_flat)); // R4

    AST_NO_PARTIAL_COMMIT: assert property (@(posedge clk) disable iff (rst)
        !rx_vld |=> $stable(cfg_flat)); // R6

    AST_VOL_WRITE: assert property (@(posedge clk) disable iff (rst)
        (rx_vld && !rx_addr && sel_q && xfer == 2'b00 && rx_bits[7:6] == 2'b00)
        |=> vol == $past(rx_bits[5:0])); // R7

    AST_MUTE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (rx_vld && !rx_addr && sel_q && xfer == 2'b00 && rx_bits[7:6] == 2'b10)
        |=> (deemph == $past(rx_bits[4:3]) && mute == $past(rx_bits[2]))); // R8
endmodule

bind ctl3w_decoder ctl3w_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .rise     (s_rise),
    .rx_vld   (rx_vld),
    .rx_addr  (rx.is_addr),
    .rx_bits  (rx.bits),
    .sel_q    (sel_q),
    .xfer     (xfer_q),
    .cfg_flat (cfg_q),
    .vol      (vol),
    .deemph   (deemph),
    .mute     (mute)
);

// File: tb/ctl3w_decoder_tb.sv
module ctl3w_decoder_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cb_mode = 1'b0;
    logic       cb_clk = 1'b1;
    logic       cb_dat = 1'b0;
    logic [1:0] clk_sel;
    logic [2:0] in_fmt;
    logic [5:0] vol;
    logic [1:0] deemph;
    logic       mute;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    ctl3w_decoder u_dut (
        .clk(clk), .rst(rst), .cb_mode(cb_mode), .cb_clk(cb_clk), .cb_dat(cb_dat),
        .clk_sel(clk_sel), .in_fmt(in_fmt), .vol(vol), .deemph(deemph), .mute(mute)
    );

    // Observed bundle: {clk_sel, in_fmt, vol, deemph, mute}
    function automatic logic [13:0] obs();
        return {clk_sel, in_fmt, vol, deemph, mute};
    endfunction

    // Entry: {req tag, address byte, data byte, expected bundle}
    localparam logic [33:0] VEC [11] = '{
        {4'd7,  8'h14, 8'h2A, 14'b00_000_101010_00_0}, // R7, also R2 (asymmetric bits)
        {4'd8,  8'h14, 8'h9C, 14'b00_000_101010_11_1}, // R8
        {4'd10, 8'h16, 8'h2A, 14'b10_101_101010_11_1}, // R10
        {4'd10, 8'h16, 8'h80, 14'b10_101_101010_11_1}, // R10 reserved selector
        {4'd4,  8'h15, 8'h3F, 14'b10_101_101010_11_1}, // R4 type 01
        {4'd4,  8'h17, 8'h00, 14'b10_101_101010_11_1}, // R4 type 11
        {4'd3,  8'h54, 8'h05, 14'b10_101_101010_11_1}, // R3 foreign address
        {4'd9,  8'h14, 8'h40, 14'b10_101_101010_11_1}, // R9 selector 01
        {4'd9,  8'h14, 8'hC2, 14'b10_101_101010_11_1}, // R9 wrong command value
        {4'd9,  8'h14, 8'hC1, 14'b00_000_000000_00_0}, // R9 restore
        {4'd7,  8'h14, 8'h07, 14'b00_000_000111_00_0}  // R7
    };

    task automatic set_mode(input logic m);
        if (cb_mode !== m) begin
            @(negedge clk) cb_mode = m;
            repeat (4) @(posedge clk);
        end
    endtask

    task automatic send_bits(input logic m, input logic [7:0] b, input int nbits);
        set_mode(m);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            cb_clk = 1'b0;
            cb_dat = b[i];
            repeat (4) @(posedge clk);
            @(negedge clk) cb_clk = 1'b1;
            repeat (4) @(posedge clk);
        end
    endtask

    task automatic send_byte(input logic m, input logic [7:0] b);
        send_bits(m, b, 8);
    endtask

    task automatic check(input string req, input logic [13:0] exp);
        @(negedge clk);
        n_chk++;
        if (obs() !== exp) begin
            n_bad++;
            $display("FAIL %s: outputs %b expected %b", req, obs(), exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    initial begin : stim
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        check("R1", 14'b0);

        for (int k = 0; k < 11; k++) begin
            send_byte(1'b0, VEC[k][29:22]);
            send_byte(1'b1, VEC[k][21:14]);
            check($sformatf("R%0d vec%0d", VEC[k][33:30], k), VEC[k][13:0]);
        end

        // R5: one address, then two data bytes in a row
        send_byte(1'b0, 8'h14);
        send_byte(1'b1, 8'h11);
        check("R5 first", 14'b00_000_010001_00_0);
        send_byte(1'b1, 8'h95);
        check("R5 second", 14'b00_000_010001_10_1);

        // R6: five bits of a data byte, then a phase change restarts counting
        send_bits(1'b1, 8'h3F, 5);
        repeat (8) @(posedge clk);
        check("R6 partial", 14'b00_000_010001_10_1);
        send_byte(1'b0, 8'h14);
        send_byte(1'b1, 8'h01);
        check("R6 restart", 14'b00_000_000001_10_1);

        // R11: sample right after the fourth system edge following the last bit
        send_byte(1'b1, 8'h0A);
        check("R11 latency", 14'b00_000_001010_10_1);

        // R3: a deselect persists across several data bytes
        send_byte(1'b0, 8'h54);
        send_byte(1'b1, 8'h3F);
        send_byte(1'b1, 8'h80);
        check("R3 persist", 14'b00_000_001010_10_1);

        // R1: mid-run reset clears everything and leaves the block deselected
        @(negedge clk) rst = 1'b1;
        repeat (2) @(posedge clk);
        check("R1 reset", 14'b0);
        @(negedge clk) rst = 1'b0;
        send_byte(1'b1, 8'h05);
        check("R1 deselected", 14'b0);

        done = 1'b1;
        finish_run();
    end
endmodule